// File: doc/BRIEF.md
# Adjustable Precision Time-of-Day Clock

This block keeps a time-of-day value for precision time synchronization. It advances once per cycle of a nominal 125 MHz reference. The value has three parts: whole seconds, nanoseconds within the second, and a fraction of a nanosecond in units of 2^-32 ns. On every reference cycle the block adds a nominal 8 ns plus a signed rate correction, and it carries nanoseconds into seconds.

A host can correct the clock in four ways. It can load a complete new time. It can add a signed nanosecond step. It can program a lasting rate correction. It can program a temporary rate correction, which runs for a set number of cycles and then gives way to the lasting rate again. Downstream logic reads the current seconds, nanoseconds and fraction directly. Time never goes negative: a backward step that would pass zero leaves the clock at zero.

Top module: `tod_clock`

## Requirements
- R1: While reset is held, seconds, nanoseconds and fraction are all zero and `tempActive` is low.
- R2: With no command, each reference cycle adds 8 ns plus the effective rate correction to the nanoseconds-and-fraction value. The effective rate is the temporary rate while one is running, and the lasting rate otherwise.
- R3: Nanoseconds always stay below 1,000,000,000. When an update reaches or passes that value, 1,000,000,000 is removed and seconds increase by one.
- R4: A set command loads seconds, nanoseconds and fraction in the next cycle, with no increment added in that cycle. A nanoseconds value above 999,999,999 is loaded as 999,999,999.
- R5: A step command adds its signed nanosecond value, in two's complement, on top of that cycle's increment. A positive result may carry one or two seconds.
- R6: A negative step that borrows decrements seconds by one or two. If the result would fall below zero time, seconds, nanoseconds and fraction all become zero.
- R7: A lasting rate command (`rateTemp`=0) sets a sign-magnitude correction. `rateNeg`=1 subtracts and `rateNeg`=0 adds `rateMag` units of 2^-32 ns per cycle. It takes effect from the cycle after the command.
- R8: A temporary rate command (`rateTemp`=1) with `rateDur`=N>0 applies its rate to exactly the next N increments and then returns to the lasting rate. `tempActive` is high during exactly those N cycles.
- R9: A temporary rate command with `rateDur`=0 cancels any running temporary rate. A lasting rate command also cancels a running temporary rate.
- R10: When set and step arrive in the same cycle, the set wins and the step is dropped.
- R11: A rate command issued in the same cycle as a step does not change that cycle's increment. The step is applied on top of the previously effective rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, nominal 125 MHz |
| rstN | input | 1 | Active-low synchronous reset |
| setValid | input | 1 | Load a new time this cycle |
| setSec | input | 32 | Seconds to load |
| setNs | input | 30 | Nanoseconds to load (clamped to 999,999,999) |
| setFrac | input | 32 | Fractional nanoseconds to load, 2^-32 ns units |
| stepValid | input | 1 | Add a signed nanosecond step this cycle |
| stepNs | input | STEP_W (31) | Signed step in ns, two's complement |
| rateValid | input | 1 | Rate command this cycle |
| rateNeg | input | 1 | Rate direction, 1 = slower |
| rateMag | input | RATE_W (32) | Rate magnitude, 2^-32 ns per cycle |
| rateTemp | input | 1 | 1 = temporary rate, 0 = lasting rate |
| rateDur | input | DUR_W (16) | Temporary rate length in cycles |
| todSec | output | 32 | Current seconds |
| todNs | output | 30 | Current nanoseconds |
| todFrac | output | 32 | Current fractional nanoseconds |
| tempActive | output | 1 | A temporary rate is in force |

## Verification
A wrong rate register or a mis-selected increment shows up in `todFrac` and `todNs` at the first idle edge after the command. The fraction reveals errors below one nanosecond straight away. A faulty carry or borrow shows up as a seconds value that is wrong by one or two, or as nanoseconds at or above one billion, on the edge that crosses the boundary. A temporary-rate counter that is off by one shows up as `tempActive`, and the fraction, being wrong for one cycle at the end of the window. Because every output is compared on every cycle, any divergence is reported in the cycle it first appears.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int SEC_W  = 32;
  localparam int NS_W   = 30;
  localparam int FRAC_W = 32;
  localparam int INC_W  = FRAC_W + 6;

  typedef struct packed {
    logic                    load;
    logic                    step;
    logic signed [INC_W-1:0] inc;
  } todStrobe_t;
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int NOMINAL_NS = 8,
  parameter int RATE_W     = 32,
  parameter int DUR_W      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic              stepValid,
  input  logic              rateValid,
  input  logic              rateNeg,
  input  logic [RATE_W-1:0] rateMag,
  input  logic              rateTemp,
  input  logic [DUR_W-1:0]  rateDur,
  output todStrobe_t        strobe,
  output logic              tempActive
);
  localparam logic signed [INC_W-1:0] NOMINAL_INC = INC_W'(NOMINAL_NS) <<< FRAC_W;

  logic              baseNeg, tmpNeg;
  logic [RATE_W-1:0] baseMag, tmpMag;
  logic [DUR_W-1:0]  tmpLeft;

  logic              useTemp, selNeg;
  logic [RATE_W-1:0] selMag;
  logic signed [INC_W-1:0] magExt;

  assign useTemp = (tmpLeft != '0);
  assign selNeg  = useTemp ? tmpNeg : baseNeg;
  assign selMag  = useTemp ? tmpMag : baseMag;
  assign magExt  = $signed({{(INC_W-RATE_W){1'b0}}, selMag});

  always_comb begin
    strobe.load = setValid;
    strobe.step = stepValid && !setValid;
    strobe.inc  = selNeg ? (NOMINAL_INC - magExt) : (NOMINAL_INC + magExt);
  end

  assign tempActive = useTemp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseNeg <= 1'b0;
      baseMag <= '0;
      tmpNeg  <= 1'b0;
      tmpMag  <= '0;
      tmpLeft <= '0;
    end else if (rateValid) begin
      if (!rateTemp) begin
        baseNeg <= rateNeg;
        baseMag <= rateMag;
        tmpLeft <= '0;
      end else begin
        tmpNeg  <= rateNeg;
        tmpMag  <= rateMag;
        tmpLeft <= rateDur;
      end
    end else if (useTemp) begin
      tmpLeft <= tmpLeft - DUR_W'(1);
    end
  end
endmodule

// File: rtl/tod_dp.sv
module tod_dp
  import tod_pkg::*;
#(
  parameter int STEP_W = 31
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  todStrobe_t               strobe,
  input  logic [SEC_W-1:0]         setSec,
  input  logic [NS_W-1:0]          setNs,
  input  logic [FRAC_W-1:0]        setFrac,
  input  logic signed [STEP_W-1:0] stepNs,
  output logic [SEC_W-1:0]         secQ,
  output logic [NS_W-1:0]          nsQ,
  output logic [FRAC_W-1:0]        fracQ
);
  localparam int ACC_W = NS_W + FRAC_W;
  localparam int SUM_W = ACC_W + 4;
  localparam logic signed [SUM_W-1:0] ONE_SEC = SUM_W'(1000000000) <<< FRAC_W;
  localparam logic signed [SUM_W-1:0] TWO_SEC = ONE_SEC <<< 1;
  localparam logic [NS_W-1:0] NS_MAX = NS_W'(999999999);

  logic signed [SUM_W-1:0] accExt, incExt, stepExt, sum;
  logic [ACC_W-1:0] rem;
  logic up1, up2, dn1, dn2, underflow;
  logic [SEC_W-1:0] secNext;

  assign accExt  = $signed({{(SUM_W-ACC_W){1'b0}}, nsQ, fracQ});
  assign incExt  = SUM_W'($signed(strobe.inc));
  assign stepExt = strobe.step ? (SUM_W'(stepNs) <<< FRAC_W) : '0;
  assign sum     = accExt + incExt + stepExt;

  always_comb begin
    up1 = 1'b0; up2 = 1'b0; dn1 = 1'b0; dn2 = 1'b0;
    rem = ACC_W'(sum);
    if (sum < 0) begin
      if (sum + ONE_SEC >= 0) begin
        dn1 = 1'b1;
        rem = ACC_W'(sum + ONE_SEC);
      end else begin
        dn2 = 1'b1;
        rem = ACC_W'(sum + TWO_SEC);
      end
    end else if (sum >= TWO_SEC) begin
      up2 = 1'b1;
      rem = ACC_W'(sum - TWO_SEC);
    end else if (sum >= ONE_SEC) begin
      up1 = 1'b1;
      rem = ACC_W'(sum - ONE_SEC);
    end
  end

  always_comb begin
    secNext = secQ;
    if (up1)      secNext = secQ + SEC_W'(1);
    else if (up2) secNext = secQ + SEC_W'(2);
    else if (dn1) secNext = secQ - SEC_W'(1);
    else if (dn2) secNext = secQ - SEC_W'(2);
  end

  assign underflow = (dn1 && secQ == '0) || (dn2 && secQ < SEC_W'(2));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= '0;
      nsQ   <= '0;
      fracQ <= '0;
    end else if (strobe.load) begin
      secQ  <= setSec;
      nsQ   <= (setNs > NS_MAX) ? NS_MAX : setNs;
      fracQ <= setFrac;
    end else if (underflow) begin
      secQ  <= '0;
      nsQ   <= '0;
      fracQ <= '0;
    end else begin
      secQ  <= secNext;
      nsQ   <= rem[ACC_W-1:FRAC_W];
      fracQ <= rem[FRAC_W-1:0];
    end
  end
endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int NOMINAL_NS = 8,
  parameter int RATE_W     = 32,
  parameter int STEP_W     = 31,
  parameter int DUR_W      = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     setValid,
  input  logic [SEC_W-1:0]         setSec,
  input  logic [NS_W-1:0]          setNs,
  input  logic [FRAC_W-1:0]        setFrac,
  input  logic                     stepValid,
  input  logic signed [STEP_W-1:0] stepNs,
  input  logic                     rateValid,
  input  logic                     rateNeg,
  input  logic [RATE_W-1:0]        rateMag,
  input  logic                     rateTemp,
  input  logic [DUR_W-1:0]         rateDur,
  output logic [SEC_W-1:0]         todSec,
  output logic [NS_W-1:0]          todNs,
  output logic [FRAC_W-1:0]        todFrac,
  output logic                     tempActive
);
  todStrobe_t strobe;

  tod_ctrl #(.NOMINAL_NS(NOMINAL_NS), .RATE_W(RATE_W), .DUR_W(DUR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .setValid(setValid), .stepValid(stepValid),
    .rateValid(rateValid), .rateNeg(rateNeg), .rateMag(rateMag),
    .rateTemp(rateTemp), .rateDur(rateDur), .strobe(strobe),
    .tempActive(tempActive)
  );

  tod_dp #(.STEP_W(STEP_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .setSec(setSec), .setNs(setNs),
    .setFrac(setFrac), .stepNs(stepNs), .secQ(todSec), .nsQ(todNs),
    .fracQ(todFrac)
  );
endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int STEP_W = 31,
  parameter int DUR_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     setValid,
  input logic [SEC_W-1:0]         setSec,
  input logic [NS_W-1:0]          setNs,
  input logic [FRAC_W-1:0]        setFrac,
  input logic                     stepValid,
  input logic signed [STEP_W-1:0] stepNs,
  input logic                     rateValid,
  input logic                     rateTemp,
  input logic [DUR_W-1:0]         rateDur,
  input logic [SEC_W-1:0]         todSec,
  input logic [NS_W-1:0]          todNs,
  input logic [FRAC_W-1:0]        todFrac,
  input logic                     tempActive
);
  p_ns_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    todNs < NS_W'(1000000000));

  p_set_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    setValid && setNs < NS_W'(1000000000) |=>
      todSec == $past(setSec) && todNs == $past(setNs) && todFrac == $past(setFrac));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    !setValid && !stepValid && todSec != '1 |=>
      (todSec != $past(todSec)) || (todNs > $past(todNs)));

  p_temp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rateValid && !tempActive |=> !tempActive);

  p_temp_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    rateValid && rateTemp && rateDur != '0 |=> tempActive);

  p_temp_cancel_r9: assert property (@(posedge clk) disable iff (!rstN)
    rateValid && (!rateTemp || rateDur == '0) |=> !tempActive);

  p_step_unused_r10: assert property (@(posedge clk) disable iff (!rstN)
    setValid && stepValid && setNs < NS_W'(1000000000) |=> todNs == $past(setNs));

  wire unusedStep = ^stepNs;
endmodule

bind tod_clock tod_checker #(.RATE_W(RATE_W), .STEP_W(STEP_W), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rstN(rstN), .setValid(setValid), .setSec(setSec), .setNs(setNs),
  .setFrac(setFrac), .stepValid(stepValid), .stepNs(stepNs),
  .rateValid(rateValid), .rateTemp(rateTemp), .rateDur(rateDur),
  .todSec(todSec), .todNs(todNs), .todFrac(todFrac), .tempActive(tempActive)
);

// File: tb/sim_tod_clock.sv
`timescale 1ns/1ps
module sim_tod_clock;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic setValid = 0, stepValid = 0, rateValid = 0, rateNeg = 0, rateTemp = 0;
  logic [31:0] setSec = 0, setFrac = 0, rateMag = 0;
  logic [29:0] setNs = 0;
  logic signed [30:0] stepNs = 0;
  logic [15:0] rateDur = 0;
  logic [31:0] todSec, todFrac;
  logic [29:0] todNs;
  logic tempActive;

  always #10 clk = ~clk;

  tod_clock u0 (
    .clk(clk), .rstN(rstN), .setValid(setValid), .setSec(setSec), .setNs(setNs),
    .setFrac(setFrac), .stepValid(stepValid), .stepNs(stepNs),
    .rateValid(rateValid), .rateNeg(rateNeg), .rateMag(rateMag),
    .rateTemp(rateTemp), .rateDur(rateDur), .todSec(todSec), .todNs(todNs),
    .todFrac(todFrac), .tempActive(tempActive)
  );

  typedef struct {
    longint sec; longint ns; longint frac; bit act; string tag;
  } exp_t;
  exp_t q[$];

  int checks = 0, failures = 0;
  bit done = 0;
  localparam longint ONE = 64'd1000000000 << 32;

  longint mSec = 0, mNf = 0, mBMag = 0, mTMag = 0;
  bit mBNeg = 0, mTNeg = 0;
  int mLeft = 0;

  task automatic apply(bit sv, longint ss, longint sn, longint sf, bit stv, longint sd,
                       bit rv, bit rn, longint rm, bit rt, int rd, string tag);
    longint inc, v, rate;
    exp_t e;
    setValid = sv; setSec = 32'(ss); setNs = 30'(sn); setFrac = 32'(sf);
    stepValid = stv; stepNs = 31'(sd);
    rateValid = rv; rateNeg = rn; rateMag = 32'(rm); rateTemp = rt; rateDur = 16'(rd);
    rate = (mLeft != 0) ? (mTNeg ? -mTMag : mTMag) : (mBNeg ? -mBMag : mBMag);
    inc = (64'd8 << 32) + rate;
    if (sv) begin
      mSec = ss;
      mNf = ((sn > 999999999) ? 64'd999999999 : sn) * (64'd1 << 32) + sf;
    end else begin
      v = mNf + inc + (stv ? sd * (64'd1 << 32) : 0);
      while (v >= ONE) begin v -= ONE; mSec++; end
      while (v < 0) begin v += ONE; mSec--; end
      if (mSec < 0) begin mSec = 0; v = 0; end
      mSec &= 64'hFFFFFFFF;
      mNf = v;
    end
    if (rv) begin
      if (!rt) begin mBNeg = rn; mBMag = rm; mLeft = 0; end
      else begin mTNeg = rn; mTMag = rm; mLeft = rd; end
    end else if (mLeft != 0) mLeft--;
    e.sec = mSec; e.ns = mNf >>> 32; e.frac = mNf & 64'hFFFFFFFF;
    e.act = (mLeft != 0); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drive(bit sv, longint ss, longint sn, longint sf, bit stv, longint sd,
                       bit rv, bit rn, longint rm, bit rt, int rd, string tag);
    @(negedge clk); #1;
    apply(sv, ss, sn, sf, stv, sd, rv, rn, rm, rt, rd, tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(0,0,0,0, 0,0, 0,0,0,0,0, tag);
  endtask

  // Monitor: compares each cycle's outputs with the queued expectation
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if ({32'b0, todSec} != e.sec || {34'b0, todNs} != e.ns ||
          {32'b0, todFrac} != e.frac || tempActive != e.act) begin
        failures++;
        $display("FAIL %s actual sec=%0d ns=%0d frac=%h act=%0d expected sec=%0d ns=%0d frac=%h act=%0d",
                 e.tag, todSec, todNs, todFrac, tempActive, e.sec, e.ns, e.frac, e.act);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (todSec != 0 || todNs != 0 || todFrac != 0 || tempActive != 0) begin
      failures++;
      $display("FAIL R1 actual sec=%0d ns=%0d frac=%h act=%0d expected all zero",
               todSec, todNs, todFrac, tempActive);
    end
    #1; rstN = 1;
    apply(0,0,0,0, 0,0, 0,0,0,0,0, "R1_first_tick");
    idle(8, "R2_free_run");

    // R3: rollover from set value
    drive(1, 5, 999999990, 0, 0,0, 0,0,0,0,0, "R4_set");
    idle(3, "R3_rollover");
    // R4: clamp of oversize nanoseconds
    drive(1, 7, 1073741823, 32'h1234, 0,0, 0,0,0,0,0, "R4_clamp");
    idle(2, "R3_after_clamp");

    // R5: positive steps, single and double carry
    drive(1, 10, 1000, 0, 0,0, 0,0,0,0,0, "R4_set");
    drive(0,0,0,0, 1, 100, 0,0,0,0,0, "R5_step_pos");
    drive(1, 10, 999999990, 0, 0,0, 0,0,0,0,0, "R4_set");
    drive(0,0,0,0, 1, 1073741823, 0,0,0,0,0, "R5_step_two_carry");
    idle(1, "R5_after");

    // R6: borrows and saturation
    drive(1, 3, 5, 0, 0,0, 0,0,0,0,0, "R4_set");
    drive(0,0,0,0, 1, -1000, 0,0,0,0,0, "R6_borrow_one");
    drive(1, 3, 5, 0, 0,0, 0,0,0,0,0, "R4_set");
    drive(0,0,0,0, 1, -1073741824, 0,0,0,0,0, "R6_borrow_two");
    drive(1, 0, 100, 0, 0,0, 0,0,0,0,0, "R4_set");
    drive(0,0,0,0, 1, -1000000000, 0,0,0,0,0, "R6_saturate");
    idle(2, "R6_after_zero");

    // R7: lasting rate, positive then negative
    drive(0,0,0,0, 0,0, 1, 0, 32'h80000000, 0, 0, "R7_rate_pos_cmd");
    idle(4, "R7_rate_pos");
    drive(0,0,0,0, 0,0, 1, 1, 32'h40000000, 0, 0, "R7_rate_neg_cmd");
    idle(4, "R7_rate_neg");

    // R8: temporary rate for 3 cycles, then back to lasting rate
    drive(0,0,0,0, 0,0, 1, 0, 32'h20000000, 1, 3, "R8_temp_cmd");
    idle(6, "R8_temp_window");
    // R9: zero duration cancels, lasting load cancels
    drive(0,0,0,0, 0,0, 1, 1, 32'h10000000, 1, 5, "R8_temp_cmd");
    idle(1, "R8_temp_run");
    drive(0,0,0,0, 0,0, 1, 0, 0, 1, 0, "R9_zero_dur_cancel");
    idle(2, "R9_after_cancel");
    drive(0,0,0,0, 0,0, 1, 0, 32'hFFFFFFFF, 1, 10, "R8_temp_cmd");
    idle(1, "R8_temp_run");
    drive(0,0,0,0, 0,0, 1, 0, 0, 0, 0, "R9_lasting_cancel");
    idle(3, "R9_after_lasting");

    // R10: set beats step
    drive(1, 42, 500, 7, 1, 12345, 0,0,0,0,0, "R10_set_over_step");
    idle(1, "R10_after");
    // R11: rate command with step uses the old rate this cycle
    drive(0,0,0,0, 1, 64, 1, 0, 32'hC0000000, 0, 0, "R11_step_with_rate");
    idle(2, "R11_new_rate");
    drive(0,0,0,0, 1, -64, 1, 1, 32'h80000000, 1, 2, "R11_step_with_temp");
    idle(4, "R11_temp_after");

    idle(2, "R2_tail");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule